// File: doc/BRIEF.md
# UART Frame Transmitter

This block turns bytes into asynchronous serial frames on one output line. A byte enters through a valid/ready stream port and is held in a single-entry holding stage (character mode). When the block is enabled and its transmit path is enabled, the byte moves into a shift stage and goes out as a frame: a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts 16 pulses of an external baud-tick strobe, which runs at 16 times the bit rate.

The frame shape comes from a set of plain line-control pins: word length, parity enable, even select, stick parity, two-stop select and break. These fields are captured when a character starts, so changing them mid-frame does not disturb that frame. Break holds the line low, but only once the character in progress is complete. Clearing either enable mid-character also lets that character finish; no new character starts until both enables are set again.

Back-pressure on the input stream: `in_ready` is high exactly when the holding stage is empty. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. A source that raises `in_valid` while `in_ready` is low loses that byte. Nothing is queued for it, so a source that needs the byte delivered must hold it until `in_ready` returns.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `tx_empty` is 1, `tx_full` is 0 and `in_ready` is 1.
- R2: A frame begins with one low start bit and then sends the data bits least significant bit first. It ends with high stop bits. Every bit lasts exactly 16 baud-tick strobes. The line idles high.
- R3: The word-length field `lc_wlen` selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits above the selected length are not sent.
- R4: With `lc_par_en`=1 and `lc_stick`=0, a parity bit follows the data. With `lc_even`=1 the number of ones in data plus parity is even; with `lc_even`=0 it is odd.
- R5: With `lc_par_en`=1 and `lc_stick`=1, the parity bit is 1 when `lc_even`=0 and 0 when `lc_even`=1.
- R6: With `lc_par_en`=0 no parity bit is sent, and `lc_even` and `lc_stick` have no effect on the frame.
- R7: With `lc_two_stop`=1, two stop bits are sent. `busy` stays high until the second stop bit has ended and then falls.
- R8: Setting `lc_break` mid-character lets that character finish. After that, `txd` stays low, and no held character starts while break stays set.
- R9: `busy` and `tx_full` go high on the edge that accepts a byte, even when `core_en`=0. `tx_empty` reports the opposite of `tx_full`.
- R10: `in_ready` is the inverse of `tx_full`. A valid byte presented while the holding stage is full is discarded.
- R11: Clearing `xmit_en` or `core_en` mid-character lets that character finish. A held character then waits, with the line high, until both enables are set again.
- R12: A character waiting in the holding stage starts on the edge that ends the last stop bit of the previous frame, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream valid for a byte to send |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Holding stage can take a byte |
| lc_wlen | input | 2 | Word length code |
| lc_par_en | input | 1 | Parity bit enable |
| lc_even | input | 1 | Even parity select |
| lc_stick | input | 1 | Stick parity select |
| lc_two_stop | input | 1 | Two stop bits select |
| lc_break | input | 1 | Hold the line low after the current character |
| core_en | input | 1 | Block enable |
| xmit_en | input | 1 | Transmit path enable |
| baud_tick | input | 1 | Strobe at 16 times the bit rate |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Holding stage full or frame in progress |
| tx_empty | output | 1 | Holding stage empty |
| tx_full | output | 1 | Holding stage full |

## Verification
Two functions can fall on the same clock edge: the shift stage ending the last stop bit of one frame, and the same stage loading the character that waits in the holding stage. This case is set up by writing a second byte while the first frame is still shifting. The line is then sampled as one continuous run of bit slots across both frames, and the test requires the second start bit to sit in the slot right after the first frame's stop bit. Break set during a frame is judged the same way: the frame's own bits must be intact, and the line must go low only once that frame is over.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } tx_state_e;

  // Frame settings captured when a character starts
  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       two_stop;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);

  assign wr_ready = !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (wr_valid && wr_ready) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        wlen,
  input  logic              even,
  input  logic              stick,
  output logic              par_bit
);

  localparam int MIN_BITS = DATA_W - 3;

  logic [DATA_W-1:0] keep;
  logic              ones_odd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    assign keep[i] = (32'(i) < (32'(MIN_BITS) + 32'(wlen)));
  end

  assign ones_odd = ^(data & keep);

  always_comb begin
    if (stick)     par_bit = !even;
    else if (even) par_bit = ones_odd;
    else           par_bit = !ones_odd;
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              ready_go,
  input  logic [DATA_W-1:0] ld_data,
  input  frame_cfg_t        ld_cfg,
  input  logic              ld_par_bit,
  input  logic              brk,
  output logic              take,
  output logic              active,
  output logic              line
);

  localparam int TICK_W   = $clog2(OVERSAMPLE);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;

  tx_state_e         state;
  frame_cfg_t        cfg_q;
  logic              par_q;
  logic [DATA_W-1:0] shreg;
  logic [TICK_W-1:0] tcnt;
  logic [IDX_W-1:0]  bidx;
  logic [IDX_W-1:0]  last_idx;
  logic              bit_end;
  logic              final_stop;

  assign last_idx   = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_q.wlen);
  assign bit_end    = baud_tick && (tcnt == TICK_W'(OVERSAMPLE - 1));
  assign final_stop = (state == ST_STOP2) || ((state == ST_STOP1) && !cfg_q.two_stop);
  assign take       = ready_go && ((state == ST_IDLE) || (bit_end && final_stop));
  assign active     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cfg_q <= '0;
      par_q <= 1'b0;
      shreg <= '0;
      tcnt  <= '0;
      bidx  <= '0;
    end else if (take) begin
      state <= ST_START;
      cfg_q <= ld_cfg;
      par_q <= ld_par_bit;
      shreg <= ld_data;
      tcnt  <= '0;
      bidx  <= '0;
    end else if (active && baud_tick) begin
      if (bit_end) begin
        tcnt <= '0;
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (bidx == last_idx) state <= cfg_q.par_en ? ST_PAR : ST_STOP1;
            else                  bidx  <= bidx + 1'b1;
          end
          ST_PAR:   state <= ST_STOP1;
          ST_STOP1: state <= cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
          default:  state <= ST_IDLE;
        endcase
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      ST_IDLE:  line = !brk;
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [1:0]        lc_wlen,
  input  logic              lc_par_en,
  input  logic              lc_even,
  input  logic              lc_stick,
  input  logic              lc_two_stop,
  input  logic              lc_break,
  input  logic              core_en,
  input  logic              xmit_en,
  input  logic              baud_tick,
  output logic              txd,
  output logic              busy,
  output logic              tx_empty,
  output logic              tx_full
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              active;
  logic              par_bit;
  logic              ready_go;
  frame_cfg_t        live_cfg;

  assign live_cfg = '{wlen: lc_wlen, par_en: lc_par_en, two_stop: lc_two_stop};
  assign ready_go = hold_full && core_en && xmit_en && !lc_break;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (in_valid),
    .wr_data  (in_data),
    .wr_ready (in_ready),
    .take     (take),
    .hold_data(hold_data),
    .hold_full(hold_full)
  );

  uart_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data   (hold_data),
    .wlen   (lc_wlen),
    .even   (lc_even),
    .stick  (lc_stick),
    .par_bit(par_bit)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .ready_go  (ready_go),
    .ld_data   (hold_data),
    .ld_cfg    (live_cfg),
    .ld_par_bit(par_bit),
    .brk       (lc_break),
    .take      (take),
    .active    (active),
    .line      (txd)
  );

  assign busy     = hold_full || active;
  assign tx_full  = hold_full;
  assign tx_empty = !hold_full;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic lc_break,
  input logic txd,
  input logic busy,
  input logic tx_full
);

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> tx_full); // R10

  AST_FULL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> busy); // R9

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !lc_break) |-> txd); // R2

  AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && lc_break) |-> !txd); // R8

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_full) |-> (!txd && busy)); // R12

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .lc_break(lc_break),
  .txd     (txd),
  .busy    (busy),
  .tx_full (tx_full)
);

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [1:0] wlen = 2'b11;
  logic       pen = 1'b0, even = 1'b0, stick = 1'b0, two = 1'b0, brk = 1'b0;
  logic       uen = 1'b1, ten = 1'b1;
  logic       baud_tick = 1'b0;
  logic       txd, busy, tx_empty, tx_full;

  int checks = 0;
  int failures = 0;
  int tick_div = 1;
  int tick_cnt = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin
      tick_cnt = 0;
      baud_tick = 1'b1;
    end else begin
      tick_cnt++;
      baud_tick = 1'b0;
    end
  end

  uart_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .lc_wlen(wlen), .lc_par_en(pen), .lc_even(even), .lc_stick(stick),
    .lc_two_stop(two), .lc_break(brk), .core_en(uen), .xmit_en(ten),
    .baud_tick(baud_tick), .txd(txd), .busy(busy), .tx_empty(tx_empty), .tx_full(tx_full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected line bits, slot 0 = start bit
  function automatic logic [31:0] frame_bits(input logic [7:0] d, output int len);
    logic [31:0] v = '0;
    int n = 5 + int'(wlen);
    int p = 0;
    int ones = 0;
    p = 1;
    for (int i = 0; i < n; i++) begin
      v[p] = d[i];
      ones += int'(d[i]);
      p++;
    end
    if (pen) begin
      if (stick) v[p] = !even;
      else v[p] = even ? logic'(ones % 2) : logic'(1 - ones % 2);
      p++;
    end
    v[p] = 1'b1; p++;
    if (two) begin v[p] = 1'b1; p++; end
    len = p;
    return v;
  endfunction

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Sample n bit slots from the next start bit, at mid-bit
  task automatic grab(input int n, input int drop_at, input int brk_at, output logic [31:0] got);
    int to = 0;
    got = '0;
    @(negedge clk);
    while (txd !== 1'b0 && to < 4000) begin
      @(negedge clk);
      to++;
    end
    if (to >= 4000) begin
      checks++; failures++;
      $display("FAIL grab no start bit actual=%b expected=0", txd);
    end
    repeat (8 * tick_div - 1) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (16 * tick_div) @(negedge clk);
      got[i] = txd;
      if (i == drop_at) ten = 1'b0;
      if (i == brk_at) brk = 1'b1;
    end
  endtask

  task automatic wait_idle();
    int to = 0;
    while (busy !== 1'b0 && to < 4000) begin
      @(negedge clk);
      to++;
    end
  endtask

  task automatic run_frame(input string tag, input logic [7:0] d);
    logic [31:0] got, exp;
    int len;
    exp = frame_bits(d, len);
    send(d);
    grab(len, -1, -1, got);
    chk(tag, got, exp);
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R1 txd", 32'(txd), 1);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 tx_empty", 32'(tx_empty), 1);
    chk("R1 tx_full", 32'(tx_full), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
  endtask

  task automatic t_formats();
    wlen = 2'b11; pen = 0; two = 0;
    run_frame("R2 8N1 A5", 8'hA5);
    tick_div = 3;
    run_frame("R2 16 ticks per bit, slow tick", 8'h3C);
    tick_div = 1;
    wlen = 2'b00; run_frame("R3 5 bits", 8'hFF);
    wlen = 2'b01; run_frame("R3 6 bits", 8'hE6);
    wlen = 2'b10; run_frame("R3 7 bits", 8'h55);
    wlen = 2'b11; pen = 1; even = 1; stick = 0;
    run_frame("R4 even parity", 8'h13);
    even = 0; run_frame("R4 odd parity", 8'h13);
    wlen = 2'b00; even = 1; run_frame("R4 even parity 5 bits", 8'hF1);
    wlen = 2'b11; stick = 1; even = 0; run_frame("R5 stick one", 8'h00);
    even = 1; run_frame("R5 stick zero", 8'hFF);
    pen = 0; even = 1; stick = 1; run_frame("R6 parity off", 8'h81);
    stick = 0; even = 0;
  endtask

  task automatic t_two_stop();
    logic [31:0] got, exp;
    int len;
    two = 1;
    exp = frame_bits(8'h6B, len);
    send(8'h6B);
    grab(len, -1, -1, got);
    chk("R7 two stop frame", got, exp);
    repeat (8) @(negedge clk);
    chk("R7 busy through stop2", 32'(busy), 1);
    @(negedge clk);
    chk("R7 busy falls after stop2", 32'(busy), 0);
    chk("R7 line high after frame", 32'(txd), 1);
    two = 0;
  endtask

  task automatic t_disabled();
    logic [31:0] got, exp;
    int len;
    uen = 0;
    send(8'h3C);
    chk("R9 busy while disabled", 32'(busy), 1);
    chk("R9 tx_full", 32'(tx_full), 1);
    chk("R9 tx_empty", 32'(tx_empty), 0);
    chk("R10 in_ready low when full", 32'(in_ready), 0);
    send(8'h99);
    repeat (60) @(negedge clk);
    chk("R11 line high while disabled", 32'(txd), 1);
    exp = frame_bits(8'h3C, len);
    uen = 1;
    grab(len, -1, -1, got);
    chk("R10 held byte kept, later byte dropped", got, exp);
    wait_idle();
    repeat (40) @(negedge clk);
    chk("R10 no second frame", 32'({busy, txd}), 32'b01);
  endtask

  task automatic t_mid_disable();
    logic [31:0] got, exp;
    int len;
    exp = frame_bits(8'h5A, len);
    send(8'h5A);
    grab(len, 3, -1, got);
    chk("R11 frame finishes after disable", got, exp);
    wait_idle();
    send(8'h11);
    repeat (100) @(negedge clk);
    chk("R11 held char waits", 32'({busy, tx_full, txd}), 32'b111);
    exp = frame_bits(8'h11, len);
    ten = 1;
    grab(len, -1, -1, got);
    chk("R11 resumes on enable", got, exp);
    wait_idle();
  endtask

  task automatic t_break();
    logic [31:0] got, exp;
    int len;
    exp = frame_bits(8'hF0, len);
    send(8'hF0);
    grab(len, -1, 2, got);
    chk("R8 frame completes under break", got, exp);
    wait_idle();
    repeat (5) @(negedge clk);
    chk("R8 line low after frame", 32'(txd), 0);
    send(8'h77);
    repeat (50) @(negedge clk);
    chk("R8 no start during break", 32'({tx_full, txd}), 32'b10);
    exp = frame_bits(8'h77, len);
    brk = 0;
    grab(len, -1, -1, got);
    chk("R8 held char sent after break", got, exp);
    wait_idle();
  endtask

  task automatic t_back_to_back();
    logic [31:0] got, e1, e2;
    int l1, l2;
    wlen = 2'b11; pen = 1; even = 1;
    e1 = frame_bits(8'h81, l1);
    e2 = frame_bits(8'h42, l2);
    send(8'h81);
    send(8'h42);
    chk("R9 second byte held while shifting", 32'(tx_full), 1);
    grab(l1 + l2, -1, -1, got);
    chk("R12 frames with no gap", got, e1 | (e2 << l1));
    wait_idle();
    pen = 0; even = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_two_stop();
    t_disabled();
    t_mid_disable();
    t_break();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule